// File: doc/BRIEF.md
# Three-Level Performance Point Controller

This block selects one of three performance points for a small microcontroller-style system. Software writes a two-bit level code into a control register. From the single fast system clock the block derives a one-cycle clock-enable strobe at the divided rate for that level. Downstream logic advances only on cycles where the strobe is high. No second clock is ever generated.

Alongside the strobe the block reports a modelled supply-voltage code. Nothing analog is driven; the code exists for power bookkeeping and estimation. A status word reads back the level in force and whether a request is still waiting.

A new request is never applied in the middle of a division period. The controller holds it until the running period has closed, then switches. No strobe interval is ever shorter than the period of the level that produced it, so a consumer sees no truncated period.

Top module: `perf_level_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the status reads applied level 2'b00 (High) with the busy bit (status bit 2) clear. The enable is high and the voltage code is 2'b10.
- R2: While the applied level is High (code 2'b00), the enable is high on every cycle (divide by 1).
- R3: While the applied level is Balanced (code 2'b01), the enable is a one-cycle pulse on every second cycle (divide by DIV_BAL, default 2).
- R4: While the applied level is Eco (code 2'b10), the enable is a one-cycle pulse on every fourth cycle (divide by DIV_ECO, default 4).
- R5: The voltage code follows the applied level: High gives 2'b10 (nominal), Balanced gives 2'b01, and Eco gives 2'b00 (reduced).
- R6: The applied level changes only on the cycle after an enable pulse, that is, once the running period has completed. The first enable at the new level falls exactly N cycles after that pulse, where N is the new divide ratio. Status bits [1:0] carry the applied level.
- R7: From the cycle after a write of a valid level that differs from the applied level, status bit 2 (busy) reads 1 until the new level is applied. A write of the level already applied leaves busy at 0.
- R8: A write of the reserved code 2'b11 is ignored. The applied level, the pending request and the busy bit are all unchanged.
- R9: If several valid levels are written while a change is pending, only the last one written is applied. Earlier ones are never applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Write strobe of the level control register |
| cfg_wr_data | input | 2 | Requested level code |
| clk_en | output | 1 | Divided-rate clock-enable strobe |
| volt_code | output | 2 | Modelled voltage code for the applied level |
| status | output | 3 | {busy, applied level[1:0]} |

## Verification
A write is registered on the edge that samples it, so busy is due on the very next cycle. The new level is applied one cycle after the next enable pulse. The first enable at the new level follows N cycles after that. The voltage code moves in the same cycle as the applied level. The bench drives inputs and samples outputs on the falling edge, so each of these results is seen one sample after the edge that makes it. Its monitor measures every gap between strobes in samples and compares it with the ratio of the level in force. This check does not depend on where in the period a write landed. A scoreboard queue holds the levels the driver expects to be applied, in order, so a level that should never be applied shows up as a mismatch or as an unexpected change.

// File: rtl/perf_lvl_pkg.sv
package perf_lvl_pkg;

  typedef enum logic [1:0] {
    LVL_HIGH = 2'b00,
    LVL_BAL  = 2'b01,
    LVL_ECO  = 2'b10,
    LVL_RSVD = 2'b11
  } lvl_e;

  localparam logic [1:0] VOLT_NOM = 2'b10;
  localparam logic [1:0] VOLT_MID = 2'b01;
  localparam logic [1:0] VOLT_LOW = 2'b00;

  // a code may be adopted as a request unless it is the reserved one
  function automatic logic lvl_valid(input logic [1:0] code);
    return code != LVL_RSVD;
  endfunction

  // modelled supply code reported for a level
  function automatic logic [1:0] volt_of(input lvl_e lvl);
    case (lvl)
      LVL_HIGH: return VOLT_NOM;
      LVL_BAL:  return VOLT_MID;
      default:  return VOLT_LOW;
    endcase
  endfunction

  // divide ratio of a level
  function automatic int unsigned ratio_of(input lvl_e lvl,
                                           input int unsigned bal,
                                           input int unsigned eco);
    case (lvl)
      LVL_HIGH: return 1;
      LVL_BAL:  return bal;
      default:  return eco;
    endcase
  endfunction

endpackage

// File: rtl/perf_lvl_request.sv
module perf_lvl_request
  import perf_lvl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_data,
  output lvl_e       req_lvl,
  output logic       wr_accept
);

  assign wr_accept = wr_en && lvl_valid(wr_data);

  always_ff @(posedge clk) begin
    if (!rst_n)         req_lvl <= LVL_HIGH;
    else if (wr_accept) req_lvl <= lvl_e'(wr_data);
  end

endmodule

// File: rtl/perf_lvl_divider.sv
module perf_lvl_divider
  import perf_lvl_pkg::*;
#(
  parameter int unsigned DIV_BAL = 2,
  parameter int unsigned DIV_ECO = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  lvl_e cur_lvl,
  output logic period_done
);

  localparam int unsigned CW = (DIV_ECO > 2) ? $clog2(DIV_ECO) : 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] term;

  assign term        = CW'(ratio_of(cur_lvl, DIV_BAL, DIV_ECO) - 1);
  assign period_done = (cnt == term);

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (period_done) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/perf_lvl_apply.sv
module perf_lvl_apply
  import perf_lvl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  lvl_e       req_lvl,
  input  logic       period_done,
  output lvl_e       cur_lvl,
  output logic       switch_evt,
  output logic       pending,
  output logic [1:0] volt
);

  assign pending    = (req_lvl != cur_lvl);
  assign switch_evt = period_done && pending;
  assign volt       = volt_of(cur_lvl);

  always_ff @(posedge clk) begin
    if (!rst_n)          cur_lvl <= LVL_HIGH;
    else if (switch_evt) cur_lvl <= req_lvl;
  end

endmodule

// File: rtl/perf_level_ctrl.sv
module perf_level_ctrl
  import perf_lvl_pkg::*;
#(
  parameter int unsigned DIV_BAL = 2,
  parameter int unsigned DIV_ECO = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_wr_en,
  input  logic [1:0] cfg_wr_data,
  output logic       clk_en,
  output logic [1:0] volt_code,
  output logic [2:0] status
);

  lvl_e req_lvl;
  lvl_e cur_lvl;
  logic wr_accept;
  logic period_done;
  logic switch_evt;
  logic pending;

  perf_lvl_request u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr_en),
    .wr_data   (cfg_wr_data),
    .req_lvl   (req_lvl),
    .wr_accept (wr_accept)
  );

  perf_lvl_divider #(.DIV_BAL(DIV_BAL), .DIV_ECO(DIV_ECO)) u_div (
    .clk         (clk),
    .rst_n       (rst_n),
    .cur_lvl     (cur_lvl),
    .period_done (period_done)
  );

  perf_lvl_apply u_app (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_lvl     (req_lvl),
    .period_done (period_done),
    .cur_lvl     (cur_lvl),
    .switch_evt  (switch_evt),
    .pending     (pending),
    .volt        (volt_code)
  );

  assign clk_en = period_done;
  assign status = {pending, cur_lvl};

endmodule

// File: rtl/perf_level_ctrl_chk.sv
module perf_level_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_wr_en,
  input logic [1:0] cfg_wr_data,
  input logic       clk_en,
  input logic [2:0] status,
  input logic       switch_evt,
  input logic       wr_accept
);

  assert_high_every_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1:0] == 2'b00) |-> clk_en);

  assert_bal_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && status[1:0] == 2'b01 && !status[2]) |=> !clk_en);

  assert_eco_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && status[1:0] == 2'b10) |->
      (!$past(clk_en) && !$past(clk_en, 2) && !$past(clk_en, 3)));

  assert_switch_on_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    switch_evt |-> (clk_en && status[2]));

  assert_level_moves_after_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1:0] != $past(status[1:0])) |-> $past(clk_en));

  assert_busy_after_new_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cfg_wr_data != 2'b11 && cfg_wr_data != status[1:0] && !status[2])
      |=> status[2]);

  assert_reserved_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cfg_wr_data == 2'b11) |-> !wr_accept);

  assert_reserved_no_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en && cfg_wr_data == 2'b11 && !status[2]) |=> !status[2]);

endmodule

bind perf_level_ctrl perf_level_ctrl_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_wr_en   (cfg_wr_en),
  .cfg_wr_data (cfg_wr_data),
  .clk_en      (clk_en),
  .status      (status),
  .switch_evt  (switch_evt),
  .wr_accept   (wr_accept)
);

// File: tb/perf_level_ctrl_test.sv
module perf_level_ctrl_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr_en = 1'b0;
  logic [1:0] cfg_wr_data = 2'b00;
  logic       clk_en;
  logic [1:0] volt_code;
  logic [2:0] status;

  int nchk = 0;
  int nfail = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;
  logic [1:0] expq[$];

  always #5 clk = ~clk;

  perf_level_ctrl uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_data (cfg_wr_data),
    .clk_en      (clk_en),
    .volt_code   (volt_code),
    .status      (status)
  );

  function automatic int ratio_exp(input logic [1:0] l);
    if (l == 2'b00) return 1;
    if (l == 2'b01) return 2;
    return 4;
  endfunction

  function automatic logic [1:0] volt_exp(input logic [1:0] l);
    if (l == 2'b00) return 2'b10;
    if (l == 2'b01) return 2'b01;
    return 2'b00;
  endfunction

  function automatic string rate_tag(input logic [1:0] l);
    if (l == 2'b00) return "R2";
    if (l == 2'b01) return "R3";
    return "R4";
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  // monitor: level changes against the scoreboard, strobe spacing against the ratio
  logic [1:0] prev_lvl = 2'b00;
  int since = 0;
  bit fresh = 1'b0;
  always @(negedge clk) begin
    if (mon_on) begin
      if (status[1:0] != prev_lvl) begin
        if (expq.size() == 0) begin
          check(1'b0, "R6/R9 unexpected level change", status[1:0], prev_lvl);
        end else begin
          logic [1:0] e;
          e = expq.pop_front();
          check(status[1:0] == e, "R6 applied level", status[1:0], e);
          check(volt_code == volt_exp(status[1:0]), "R5 voltage code",
                volt_code, volt_exp(status[1:0]));
        end
        prev_lvl = status[1:0];
        since = 0;
        fresh = 1'b1;
      end
      since++;
      if (clk_en) begin
        check(since == ratio_exp(prev_lvl), fresh ? "R6 first pulse gap" : rate_tag(prev_lvl),
              since, ratio_exp(prev_lvl));
        since = 0;
        fresh = 1'b0;
      end else if (since >= ratio_exp(prev_lvl)) begin
        check(1'b0, {rate_tag(prev_lvl), " missing pulse"}, since, ratio_exp(prev_lvl));
        since = 0;
      end
    end
  end

  task automatic write_lvl(input logic [1:0] code, input bit expect_apply);
    if (expect_apply) expq.push_back(code);
    cfg_wr_en   = 1'b1;
    cfg_wr_data = code;
    @(negedge clk);
    cfg_wr_en   = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (status[2] && n < 40) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check(status == 3'b000, "R1 status in reset", status, 0);
    check(clk_en == 1'b1, "R1 enable in reset", clk_en, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(status == 3'b000, "R1 status after reset", status, 0);
    check(clk_en == 1'b1, "R1 enable after reset", clk_en, 1);
    check(volt_code == 2'b10, "R1 voltage after reset", volt_code, 2);
    mon_on = 1'b1;
    run(6);

    // R7: writing the level already applied keeps busy clear
    write_lvl(2'b00, 1'b0);
    check(status[2] == 1'b0, "R7 same level no busy", status[2], 0);

    // High -> Balanced
    write_lvl(2'b01, 1'b1);
    check(status[2] == 1'b1, "R7 busy after request", status[2], 1);
    wait_idle();
    check(status[1:0] == 2'b01, "R6 now Balanced", status[1:0], 1);
    run(10);

    // Balanced -> Eco
    write_lvl(2'b10, 1'b1);
    check(status[2] == 1'b1, "R7 busy after request", status[2], 1);
    wait_idle();
    check(status[1:0] == 2'b10, "R6 now Eco", status[1:0], 2);
    run(12);

    // R8: reserved code ignored
    write_lvl(2'b11, 1'b0);
    check(status == 3'b010, "R8 reserved write ignored", status, 2);
    run(9);
    check(status == 3'b010, "R8 still Eco, idle", status, 2);

    // R9: last pending request wins (align to the end of an Eco period)
    while (!clk_en) @(negedge clk);
    write_lvl(2'b01, 1'b0);
    check(status == 3'b110, "R9 pending after first write", status, 6);
    write_lvl(2'b00, 1'b1);
    check(status[2] == 1'b1, "R9 still pending", status[2], 1);
    wait_idle();
    check(status[1:0] == 2'b00, "R9 last request applied", status[1:0], 0);
    run(6);

    // High -> Eco, Eco -> Balanced, Balanced -> High
    write_lvl(2'b10, 1'b1);
    wait_idle();
    run(13);
    write_lvl(2'b01, 1'b1);
    check(status[2] == 1'b1, "R7 busy Eco to Balanced", status[2], 1);
    wait_idle();
    run(7);
    write_lvl(2'b00, 1'b1);
    wait_idle();
    run(5);
    check(status == 3'b000 && volt_code == 2'b10, "R5 back to nominal", {volt_code, status}, 16);
    check(expq.size() == 0, "R6 all expected levels applied", expq.size(), 0);

    done = 1'b1;
    finish_run();
  end

endmodule